// File: doc/BRIEF.md
# Tagged Granule Memory

This block is an on-chip memory organised as 128-bit granules, each paired with a single hidden validity bit. The bit lives in a separate flop array beside the data storage. It marks a granule as holding a genuine capability rather than plain data. All traffic enters through one request port with four operations: data load, data store, capability load and capability store.

Only a capability store can make the validity bit true, and only when the capability being stored is itself marked valid. Any data store that writes at least one byte of a granule clears that granule's bit. Plain loads never reveal the bit. Capability accesses must sit on a 16-byte boundary. A misaligned capability access is refused with a fault and leaves memory untouched.

Every accepted request produces exactly one response on the following cycle. The data storage is not reset, while the validity bits are cleared by reset.

Top module: `capmem_core`

## Requirements
- R1: Memory is made of 128-bit granules, each with one validity tag, selected by `req_addr[ADDR_W-1:4]`. An aligned capability load returns all 128 data bits of the granule together with its tag.
- R2: A data store with at least one bit of `req_be` set clears the granule's tag, even when only one byte is written. A data store with `req_be` all zero changes neither data nor tag.
- R3: A data load returns the granule's data and always drives `rsp_tag` low, whatever the stored tag is.
- R4: A tag can become 1 only through a capability store with `req_wtag` = 1. A capability store with `req_wtag` = 0 leaves the tag at 0.
- R5: A capability store writes all 128 data bits and the tag as one unit, whatever the value of `req_be`.
- R6: A capability load or store whose address has `req_addr[3:0]` nonzero gives `rsp_fault` = 1 with `rsp_data` = 0 and `rsp_tag` = 0. It leaves the data and the tag of every granule unchanged.
- R7: A data store writes byte lane i (`req_wdata[8i+7:8i]`) only where `req_be[i]` = 1. Every other byte keeps its old value.
- R8: Each request with `req_valid` high is answered by `rsp_valid` high exactly one cycle later, and `rsp_valid` stays low in every other cycle. Store responses carry zero data and a zero tag. A load issued in the cycle after a store to the same granule sees the stored contents.
- R9: After reset every tag reads 0. Data contents are undefined until written.
- R10: Data loads and stores ignore `req_addr[3:0]` and never fault.
- Operation encoding on `req_op`: 00 data load, 01 data store, 10 capability load, 11 capability store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see requirements) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | GRAN_W | Store data |
| req_wtag | input | 1 | Tag of the capability being stored |
| req_be | input | GRAN_W/8 | Byte enables for data stores |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | GRAN_W | Load data, zero for stores and faults |
| rsp_tag | output | 1 | Tag on capability loads, otherwise zero |
| rsp_fault | output | 1 | Misaligned capability access |

## Verification
A single-byte store into a tagged granule must clear the tag. A design that gated the clear on a full-width write would hand back a still-valid capability whose bytes have been overwritten. A store with no byte enabled must leave the tag set, and a lax decoder would clear it anyway. A misaligned capability store that carries a clear tag is followed by a load of the aligned granule. If the store leaked into the array, that load would show corrupted data or a lost tag. The bench also loads tagged granules through the data path and expects a zero tag, which catches a tag that leaks onto plain loads. Granules 0 and 63 cover both ends of the index range.

// File: rtl/capmem_pkg.sv
package capmem_pkg;

   typedef enum logic [1:0] {
      OP_DLOAD  = 2'b00,
      OP_DSTORE = 2'b01,
      OP_CLOAD  = 2'b10,
      OP_CSTORE = 2'b11
   } cap_op_e;

   typedef enum logic [2:0] {
      RK_IDLE,
      RK_DATA,
      RK_CAP,
      RK_STORE,
      RK_FAULT
   } rsp_kind_e;

endpackage

// File: rtl/capmem_req_decode.sv
module capmem_req_decode
   import capmem_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANES  = 16,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 6
) (
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  req_be,
   input  logic              req_wtag,
   output logic [IDX_W-1:0]  gran_idx,
   output logic [LANES-1:0]  lane_we,
   output logic              tag_we,
   output logic              tag_wval,
   output rsp_kind_e         rd_kind
);

   cap_op_e op;
   logic    misaligned;
   logic    is_cap;
   logic    fault;

   assign op         = cap_op_e'(req_op);
   assign gran_idx   = req_addr[ADDR_W-1:OFF_W];
   assign misaligned = |req_addr[OFF_W-1:0];
   assign is_cap     = (op == OP_CLOAD) || (op == OP_CSTORE);
   assign fault      = req_valid && is_cap && misaligned;

   always_comb begin
      lane_we  = '0;
      tag_we   = 1'b0;
      tag_wval = 1'b0;
      rd_kind  = RK_IDLE;
      if (fault) begin
         rd_kind = RK_FAULT;
      end else if (req_valid) begin
         unique case (op)
            OP_DLOAD:  rd_kind = RK_DATA;
            OP_CLOAD:  rd_kind = RK_CAP;
            OP_DSTORE: begin
               lane_we = req_be;
               tag_we  = |req_be;
               rd_kind = RK_STORE;
            end
            OP_CSTORE: begin
               lane_we  = '1;
               tag_we   = 1'b1;
               tag_wval = req_wtag;
               rd_kind  = RK_STORE;
            end
            default: rd_kind = RK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/capmem_data_bank.sv
module capmem_data_bank #(
   parameter int LANES = 16,
   parameter int IDX_W = 6
) (
   input  logic               clk,
   input  logic [IDX_W-1:0]   idx,
   input  logic [LANES-1:0]   lane_we,
   input  logic [LANES*8-1:0] wdata,
   output logic [LANES*8-1:0] rdata
);

   localparam int DEPTH = 1 << IDX_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [DEPTH];
      logic [7:0] rd_q;

      always_ff @(posedge clk) begin
         if (lane_we[l]) begin
            mem[idx] <= wdata[8*l +: 8];
         end
         rd_q <= mem[idx];
      end

      assign rdata[8*l +: 8] = rd_q;
   end

endmodule

// File: rtl/capmem_tag_array.sv
module capmem_tag_array #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             we,
   input  logic             wval,
   output logic             rtag
);

   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] tags;
   logic             rtag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tags   <= '0;
         rtag_q <= 1'b0;
      end else begin
         if (we) begin
            tags[idx] <= wval;
         end
         rtag_q <= tags[idx];
      end
   end

   assign rtag = rtag_q;

endmodule

// File: rtl/capmem_core.sv
module capmem_core
   import capmem_pkg::*;
#(
   parameter int GRAN_W = 128,
   parameter int ADDR_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [GRAN_W-1:0]   req_wdata,
   input  logic                req_wtag,
   input  logic [GRAN_W/8-1:0] req_be,
   output logic                rsp_valid,
   output logic [GRAN_W-1:0]   rsp_data,
   output logic                rsp_tag,
   output logic                rsp_fault
);

   localparam int LANES = GRAN_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int IDX_W = ADDR_W - OFF_W;

   if (GRAN_W % 8 != 0) begin : g_bad_gran
      $error("GRAN_W must be a whole number of bytes");
   end
   if ((1 << OFF_W) != LANES) begin : g_bad_lanes
      $error("GRAN_W/8 must be a power of two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the granule offset width");
   end

   logic [IDX_W-1:0]  gran_idx;
   logic [LANES-1:0]  lane_we;
   logic              tag_we;
   logic              tag_wval;
   rsp_kind_e         rd_kind;
   rsp_kind_e         kind_q;
   logic [GRAN_W-1:0] bank_rdata;
   logic              tag_rdata;

   capmem_req_decode #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .OFF_W  (OFF_W),
      .IDX_W  (IDX_W)
   ) i_decode (
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wtag  (req_wtag),
      .gran_idx  (gran_idx),
      .lane_we   (lane_we),
      .tag_we    (tag_we),
      .tag_wval  (tag_wval),
      .rd_kind   (rd_kind)
   );

   capmem_data_bank #(
      .LANES (LANES),
      .IDX_W (IDX_W)
   ) i_bank (
      .clk     (clk),
      .idx     (gran_idx),
      .lane_we (lane_we),
      .wdata   (req_wdata),
      .rdata   (bank_rdata)
   );

   capmem_tag_array #(
      .IDX_W (IDX_W)
   ) i_tags (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (gran_idx),
      .we    (tag_we),
      .wval  (tag_wval),
      .rtag  (tag_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= RK_IDLE;
      end else begin
         kind_q <= rd_kind;
      end
   end

   assign rsp_valid = (kind_q != RK_IDLE);
   assign rsp_fault = (kind_q == RK_FAULT);
   assign rsp_data  = ((kind_q == RK_DATA) || (kind_q == RK_CAP)) ? bank_rdata : '0;
   assign rsp_tag   = (kind_q == RK_CAP) ? tag_rdata : 1'b0;

endmodule

// File: rtl/capmem_checker.sv
module capmem_checker #(
   parameter int GRAN_W = 128,
   parameter int ADDR_W = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [1:0]          req_op,
   input logic [ADDR_W-1:0]   req_addr,
   input logic                req_wtag,
   input logic [GRAN_W/8-1:0] req_be,
   input logic                rsp_valid,
   input logic [GRAN_W-1:0]   rsp_data,
   input logic                rsp_tag,
   input logic                rsp_fault,
   input logic                tag_we,
   input logic                tag_wval
);

   localparam int OFF_W = $clog2(GRAN_W / 8);

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                              // R8
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                            // R8
   AST_DLOAD_HIDES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b00) |=> !rsp_tag);                          // R3
   AST_MISALIGN_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[1] && (|req_addr[OFF_W-1:0])) |=> rsp_fault);     // R6
   AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_data == '0 && !rsp_tag));                           // R6
   AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_op[1] && (|req_addr[OFF_W-1:0])) |-> !tag_we);                    // R6
   AST_TAG_UNFORGEABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_we && tag_wval) |-> (req_valid && req_op == 2'b11 && req_wtag));  // R4
   AST_DSTORE_CLEARS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b01 && (|req_be)) |-> (tag_we && !tag_wval)); // R2
   AST_EMPTY_DSTORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b01 && req_be == '0) |-> !tag_we);          // R2

endmodule

bind capmem_core capmem_checker #(
   .GRAN_W (GRAN_W),
   .ADDR_W (ADDR_W)
) i_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_addr  (req_addr),
   .req_wtag  (req_wtag),
   .req_be    (req_be),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data),
   .rsp_tag   (rsp_tag),
   .rsp_fault (rsp_fault),
   .tag_we    (tag_we),
   .tag_wval  (tag_wval)
);

// File: tb/test_capmem_core.sv
`timescale 1ns/1ps
module test_capmem_core;

   localparam int GW    = 128;
   localparam int AW    = 10;
   localparam int DEPTH = 64;

   typedef struct {
      logic [GW-1:0] d;
      logic [GW-1:0] m;
      logic          t;
      logic          f;
      string         req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [GW-1:0] req_wdata = '0;
   logic          req_wtag = 1'b0;
   logic [15:0]   req_be = '0;
   logic          rsp_valid;
   logic [GW-1:0] rsp_data;
   logic          rsp_tag;
   logic          rsp_fault;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   exp_t          q[$];
   logic [GW-1:0] m_data  [DEPTH];
   logic [GW-1:0] m_known [DEPTH];
   logic          m_tag   [DEPTH];

   always #2 clk = ~clk;

   capmem_core #(.GRAN_W(GW), .ADDR_W(AW)) i_capmem_core (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_wtag (req_wtag),
      .req_be (req_be), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
      .rsp_tag (rsp_tag), .rsp_fault (rsp_fault)
   );

   task automatic check(bit ok, string req, string what, logic [GW-1:0] act, logic [GW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(logic [1:0] op, int g, int off, logic [GW-1:0] wd,
                        logic wt, logic [15:0] be, string req);
      exp_t e;
      bit   mis;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = AW'(g * 16 + off);
      req_wdata = wd; req_wtag = wt; req_be = be;
      mis = (off != 0) && op[1];
      e.d = '0; e.m = '1; e.t = 1'b0; e.f = 1'b0; e.req = req;
      if (mis) begin
         e.f = 1'b1;
      end else begin
         case (op)
            2'b00: begin e.d = m_data[g]; e.m = m_known[g]; end
            2'b10: begin e.d = m_data[g]; e.m = m_known[g]; e.t = m_tag[g]; end
            2'b01: begin
               for (int b = 0; b < 16; b++) begin
                  if (be[b]) begin
                     m_data[g][8*b +: 8]  = wd[8*b +: 8];
                     m_known[g][8*b +: 8] = 8'hFF;
                  end
               end
               if (be != 0) m_tag[g] = 1'b0;
            end
            default: begin m_data[g] = wd; m_known[g] = '1; m_tag[g] = wt; end
         endcase
      end
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t e;
         if (q.size() == 0) begin
            check(1'b0, "R8", "response without request", GW'(rsp_valid), '0);
         end else begin
            e = q.pop_front();
            check(((rsp_data ^ e.d) & e.m) == '0, e.req, "data", rsp_data, e.d);
            check(rsp_tag == e.t, e.req, "tag", GW'(rsp_tag), GW'(e.t));
            check(rsp_fault == e.f, e.req, "fault", GW'(rsp_fault), GW'(e.f));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R8", "watchdog expired", '0, '1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [GW-1:0] pat;
      for (int g = 0; g < DEPTH; g++) begin
         m_data[g] = '0; m_known[g] = '0; m_tag[g] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R8", "idle after reset", GW'(rsp_valid), '0);

      // R9: fresh granules report a clear tag
      issue(2'b10, 0, 0, '0, 1'b0, '0, "R9");
      issue(2'b10, 63, 0, '0, 1'b0, '0, "R9");
      // R1 R5: full capability store ignores byte enables, then reload
      pat = {4{32'hC0DE_0001}};
      issue(2'b11, 1, 0, pat, 1'b1, 16'h0000, "R5");
      issue(2'b10, 1, 0, '0, 1'b0, '0, "R1");
      // R3: data load of a tagged granule hides the tag
      issue(2'b00, 1, 0, '0, 1'b0, '0, "R3");
      // R2 R7: one-byte store clears tag and merges
      issue(2'b01, 1, 0, {GW{1'b1}}, 1'b1, 16'h0001, "R7");
      issue(2'b10, 1, 0, '0, 1'b0, '0, "R2");
      issue(2'b01, 1, 0, '0, 1'b0, 16'h8000, "R7");
      issue(2'b00, 1, 0, '0, 1'b0, '0, "R7");
      // R2: empty byte mask leaves data and tag
      issue(2'b11, 2, 0, {4{32'hA5A5_5A5A}}, 1'b1, '0, "R5");
      issue(2'b01, 2, 0, '0, 1'b0, 16'h0000, "R2");
      issue(2'b10, 2, 0, '0, 1'b0, '0, "R2");
      // R4: capability store with clear tag
      issue(2'b11, 3, 0, {4{32'h1234_5678}}, 1'b0, '1, "R4");
      issue(2'b10, 3, 0, '0, 1'b0, '0, "R4");
      // R6: misaligned capability store and load
      issue(2'b11, 2, 4, '0, 1'b0, '1, "R6");
      issue(2'b10, 2, 0, '0, 1'b0, '0, "R6");
      issue(2'b10, 2, 8, '0, 1'b0, '0, "R6");
      // R10: data access with offset bits set
      issue(2'b01, 4, 7, {4{32'hDEAD_BEEF}}, 1'b0, '1, "R10");
      issue(2'b00, 4, 3, '0, 1'b0, '0, "R10");
      // R8: store then load back to back on top granule, plus idle gap
      issue(2'b11, 63, 0, {2{64'hFEED_FACE_0BAD_F00D}}, 1'b1, '0, "R8");
      issue(2'b10, 63, 0, '0, 1'b0, '0, "R8");
      idle();
      @(negedge clk);
      check(rsp_valid == 1'b0, "R8", "no response when idle", GW'(rsp_valid), '0);
      // mixed sweep over several granules
      for (int g = 8; g < 16; g++) begin
         issue(2'b11, g, 0, {4{32'(g * 32'h0101_0101)}}, g[0], '0, "R5");
      end
      for (int g = 8; g < 16; g++) begin
         issue(2'b01, g, 0, {GW{1'b0}}, 1'b0, 16'(1 << (g - 8)), "R7");
         issue(2'b10, g, 0, '0, 1'b0, '0, "R2");
      end
      idle();
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R8", "responses outstanding", GW'(q.size()), '0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule